// File: doc/BRIEF.md
# Pixel Region Hit Logger

This block is the digital readout logic for one region of a binary-hit pixel sensor column. The region holds 42 pixels in 7 groups of 6, and each pixel delivers one comparator bit. A per-pixel mask suppresses noisy pixels. On every bunch-crossing strobe inside a train, the block captures the masked hit vector and tags it with a 13-bit crossing timestamp. It then visits the groups one per cycle and logs a compact record for each group that has at least one hit.

Records stay in a small local memory for the whole train. When the train ends, the memory is drained in the order the records were written. The drain uses a 30-bit parallel word with a ready/valid handshake, and a terminating word marks the end of the data. If the memory fills, further records are discarded and a sticky flag reports the loss.

Top module: `pixel_region_logger`

## Requirements
- R1: After reset, `rdValid` is 0, `rdData` is all zero and `overOvf` is 0, and the block is idle, not acquiring.
- R2: A pixel whose mask bit is 1 never contributes to a record. A group whose only hits are masked produces no record.
- R3: The crossing stamp is 0 for the first strobe after `trainStart` and rises by one per strobe, holding at 8191 once it gets there. Every record carries the stamp of its own crossing.
- R4: For each strobe during acquisition, each group with a nonzero masked pattern produces exactly one record, in ascending group order. Groups with no unmasked hit produce nothing.
- R5: Record word layout: bit 29 = 1 (valid), bits 28:22 = 0, bits 21:9 = stamp, bits 8:6 = group index, bits 5:0 = pattern, where pattern bit j is pixel `group*6 + j`.
- R6: The memory holds 19 records. Records beyond that are dropped and `overOvf` goes to 1 and stays there until the next `trainStart`, which clears it.
- R7: Pixel inputs are taken only on a strobe cycle while acquiring. Strobes before the first train, or after `trainEnd`, add no record, and pixel activity between strobes is ignored.
- R8: After `trainEnd`, `rdValid` rises on the next cycle. The words come out in write order, and each word is held unchanged until a cycle with `rdReady` high. The last word is all zero (valid bit clear). Once that word is taken, `rdValid` falls.
- R9: A one-cycle `maskWr` loads `maskData` into the mask, bit i belonging to pixel i. The new mask applies from the next strobe on.
- R10: Strobes must be at least 8 cycles apart, because visiting the 7 groups takes 7 cycles after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trainStart | input | 1 | Starts acquisition: clears stamp, memory and overflow |
| trainEnd | input | 1 | Ends acquisition and starts the drain |
| bxStrobe | input | 1 | Bunch-crossing strobe, one cycle |
| pixHit | input | 42 | Comparator bits, bit i = pixel i |
| maskWr | input | 1 | Loads the mask |
| maskData | input | 42 | New mask, 1 = pixel masked |
| rdReady | input | 1 | Consumer accepts the current word |
| rdValid | output | 1 | A readout word is presented |
| rdData | output | 30 | Readout word |
| overOvf | output | 1 | Sticky overflow flag |

## Verification
The strobe is registered on the edge where it is sampled. The record for group g is written g+1 edges later, so the bench leaves 8 idle cycles after each strobe before it drives the next one. The drain word is present one cycle after `trainEnd` is sampled and changes only on the edge after a cycle with `rdReady` high. The bench drives inputs and samples outputs on falling edges, and it withholds `rdReady` at intervals to confirm the word holds. Expected words come from an arithmetic model of the mask, stamp and memory limit, and the sweep walks every 6-bit pattern across the groups under several masks.

// File: rtl/prl_pkg.sv
package prl_pkg;
  localparam int PRL_NUM_GROUPS = 7;
  localparam int PRL_GROUP_SIZE = 6;
  localparam int PRL_TS_W       = 13;
  localparam int PRL_DEPTH      = 19;
  localparam int PRL_DATA_W     = 30;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACQ   = 2'd1,
    ST_SCAN  = 2'd2,
    ST_DRAIN = 2'd3
  } prl_state_t;

  typedef struct packed {
    logic clear;
    logic capture;
    logic scanEn;
    logic advance;
  } prl_strobe_t;
endpackage

// File: rtl/prl_ctrl.sv
module prl_ctrl
  import prl_pkg::*;
#(
  parameter int NUM_GROUPS = PRL_NUM_GROUPS,
  localparam int GRP_W = $clog2(NUM_GROUPS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trainStart,
  input  logic             trainEnd,
  input  logic             bxStrobe,
  input  logic             rdReady,
  input  logic             pending,
  output prl_strobe_t      stb,
  output logic [GRP_W-1:0] scanGrp,
  output logic             rdValid
);
  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GROUPS - 1);

  prl_state_t state, stateNxt;
  logic [GRP_W-1:0] grpNxt;

  always_comb begin
    stateNxt = state;
    grpNxt   = scanGrp;
    stb      = '0;
    if (trainStart) begin
      stb.clear = 1'b1;
      stateNxt  = ST_ACQ;
      grpNxt    = '0;
    end else begin
      case (state)
        ST_ACQ: begin
          if (bxStrobe) begin
            stb.capture = 1'b1;
            stateNxt    = ST_SCAN;
            grpNxt      = '0;
          end else if (trainEnd) begin
            stateNxt = ST_DRAIN;
          end
        end
        ST_SCAN: begin
          stb.scanEn = 1'b1;
          if (scanGrp == LAST_GRP) begin
            stateNxt = ST_ACQ;
            grpNxt   = '0;
          end else begin
            grpNxt = scanGrp + GRP_W'(1);
          end
        end
        ST_DRAIN: begin
          if (rdReady) begin
            if (pending) stb.advance = 1'b1;
            else         stateNxt    = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanGrp <= '0;
    end else begin
      state   <= stateNxt;
      scanGrp <= grpNxt;
    end
  end

  assign rdValid = (state == ST_DRAIN);

  AST_SCAN_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |-> !bxStrobe); // R10
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady && !trainStart) |=> rdValid); // R8
  AST_END_LEAVES: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdReady && !pending && !trainStart) |=> !rdValid); // R8
endmodule

// File: rtl/prl_datapath.sv
module prl_datapath
  import prl_pkg::*;
#(
  parameter int NUM_GROUPS = PRL_NUM_GROUPS,
  parameter int GROUP_SIZE = PRL_GROUP_SIZE,
  parameter int TS_W       = PRL_TS_W,
  parameter int DEPTH      = PRL_DEPTH,
  parameter int DATA_W     = PRL_DATA_W,
  localparam int NUM_PIX = NUM_GROUPS * GROUP_SIZE,
  localparam int GRP_W   = $clog2(NUM_GROUPS),
  localparam int PTR_W   = $clog2(DEPTH + 1),
  localparam int REC_W   = TS_W + GRP_W + GROUP_SIZE,
  localparam int PAD_W   = DATA_W - 1 - REC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  prl_strobe_t        stb,
  input  logic [GRP_W-1:0]   scanGrp,
  input  logic               rdValid,
  input  logic [NUM_PIX-1:0] pixHit,
  input  logic               maskWr,
  input  logic [NUM_PIX-1:0] maskData,
  output logic               pending,
  output logic [DATA_W-1:0]  rdData,
  output logic               overOvf
);
  localparam logic [TS_W-1:0]  TS_MAX  = {TS_W{1'b1}};
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH);

  logic [NUM_PIX-1:0]    maskReg;
  logic [NUM_PIX-1:0]    hitReg;
  logic [TS_W-1:0]       tsCnt;
  logic [TS_W-1:0]       stampReg;
  logic [PTR_W-1:0]      wrCnt;
  logic [PTR_W-1:0]      rdPtr;
  logic [REC_W-1:0]      mem [DEPTH];
  logic [GROUP_SIZE-1:0] grpPat [NUM_GROUPS];
  logic [GROUP_SIZE-1:0] curPat;
  logic                  full;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gSlice
    assign grpPat[g] = hitReg[g*GROUP_SIZE +: GROUP_SIZE];
  end

  assign curPat  = grpPat[scanGrp];
  assign full    = (wrCnt == PTR_TOP);
  assign pending = (rdPtr != wrCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskReg <= '0;
    else if (maskWr) maskReg <= maskData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitReg   <= '0;
      tsCnt    <= '0;
      stampReg <= '0;
      wrCnt    <= '0;
      rdPtr    <= '0;
      overOvf  <= 1'b0;
    end else if (stb.clear) begin
      hitReg   <= '0;
      tsCnt    <= '0;
      stampReg <= '0;
      wrCnt    <= '0;
      rdPtr    <= '0;
      overOvf  <= 1'b0;
    end else begin
      if (stb.capture) begin
        hitReg   <= pixHit & ~maskReg;
        stampReg <= tsCnt;
        if (tsCnt != TS_MAX) tsCnt <= tsCnt + TS_W'(1);
      end
      if (stb.scanEn && (curPat != '0)) begin
        if (full) overOvf <= 1'b1;
        else      wrCnt   <= wrCnt + PTR_W'(1);
      end
      if (stb.advance) rdPtr <= rdPtr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.scanEn && (curPat != '0) && !full && !stb.clear)
      mem[wrCnt] <= {stampReg, scanGrp, curPat};
  end

  always_comb begin
    rdData = '0;
    if (rdValid && pending) rdData = {1'b1, {PAD_W{1'b0}}, mem[rdPtr]};
  end

  AST_TS_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (tsCnt == TS_MAX && !stb.clear) |=> (tsCnt == TS_MAX)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overOvf && !stb.clear) |=> overOvf); // R6
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (full && !stb.clear) |=> (wrCnt == $past(wrCnt))); // R6
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.clear) |=> (rdPtr == $past(rdPtr) + PTR_W'(1))); // R8

  always_ff @(posedge clk) begin
    if (rstN) begin
      AST_WRCNT_BOUND: assert (wrCnt <= PTR_TOP && rdPtr <= wrCnt); // R6
    end
  end
endmodule

// File: rtl/pixel_region_logger.sv
module pixel_region_logger
  import prl_pkg::*;
#(
  parameter int NUM_GROUPS = PRL_NUM_GROUPS,
  parameter int GROUP_SIZE = PRL_GROUP_SIZE,
  parameter int TS_W       = PRL_TS_W,
  parameter int DEPTH      = PRL_DEPTH,
  parameter int DATA_W     = PRL_DATA_W,
  localparam int NUM_PIX = NUM_GROUPS * GROUP_SIZE,
  localparam int GRP_W   = $clog2(NUM_GROUPS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trainStart,
  input  logic               trainEnd,
  input  logic               bxStrobe,
  input  logic [NUM_PIX-1:0] pixHit,
  input  logic               maskWr,
  input  logic [NUM_PIX-1:0] maskData,
  input  logic               rdReady,
  output logic               rdValid,
  output logic [DATA_W-1:0]  rdData,
  output logic               overOvf
);
  prl_strobe_t      stb;
  logic [GRP_W-1:0] scanGrp;
  logic             pending;

  prl_ctrl #(.NUM_GROUPS(NUM_GROUPS)) uCtrl (
    .clk(clk), .rstN(rstN), .trainStart(trainStart), .trainEnd(trainEnd),
    .bxStrobe(bxStrobe), .rdReady(rdReady), .pending(pending),
    .stb(stb), .scanGrp(scanGrp), .rdValid(rdValid)
  );

  prl_datapath #(
    .NUM_GROUPS(NUM_GROUPS), .GROUP_SIZE(GROUP_SIZE), .TS_W(TS_W),
    .DEPTH(DEPTH), .DATA_W(DATA_W)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .scanGrp(scanGrp), .rdValid(rdValid),
    .pixHit(pixHit), .maskWr(maskWr), .maskData(maskData),
    .pending(pending), .rdData(rdData), .overOvf(overOvf)
  );
endmodule

// File: tb/tb_pixel_region_logger.sv
module tb_pixel_region_logger;
  localparam int NG = 7, GS = 6, NP = 42, DEPTH = 19, TSMAX = 8191;

  logic clk = 1'b0, rstN = 1'b0;
  logic trainStart = 0, trainEnd = 0, bxStrobe = 0, maskWr = 0, rdReady = 0;
  logic [NP-1:0] pixHit = '0, maskData = '0;
  logic rdValid, overOvf;
  logic [29:0] rdData;

  int nRun = 0, nFail = 0;
  logic [29:0] expQ[$];
  int modelTs = 0;
  bit modelOvf = 0, modelAcq = 0, finished = 0;
  logic [NP-1:0] modelMask = '0;

  always #5 clk = ~clk;

  pixel_region_logger dut (
    .clk(clk), .rstN(rstN), .trainStart(trainStart), .trainEnd(trainEnd),
    .bxStrobe(bxStrobe), .pixHit(pixHit), .maskWr(maskWr), .maskData(maskData),
    .rdReady(rdReady), .rdValid(rdValid), .rdData(rdData), .overOvf(overOvf)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic loadMask(logic [NP-1:0] m);
    maskData = m; maskWr = 1; tick(); maskWr = 0; modelMask = m;
  endtask

  task automatic startTrain();
    trainStart = 1; tick(); trainStart = 0;
    modelTs = 0; expQ.delete(); modelOvf = 0; modelAcq = 1;
  endtask

  task automatic crossing(logic [NP-1:0] hits);
    pixHit = hits; bxStrobe = 1; tick(); bxStrobe = 0;
    pixHit = '1; // noise between strobes, must be ignored (R7)
    if (modelAcq) begin
      for (int g = 0; g < NG; g++) begin
        logic [GS-1:0] p;
        p = hits[g*GS +: GS] & ~modelMask[g*GS +: GS];
        if (p != 0) begin
          if (expQ.size() < DEPTH)
            expQ.push_back({1'b1, 7'b0, 13'(modelTs), 3'(g), p});
          else modelOvf = 1;
        end
      end
      if (modelTs < TSMAX) modelTs++;
    end
    repeat (8) tick();
    pixHit = '0;
  endtask

  task automatic drain(string tag, int stallEvery);
    int idx = 0, n = 0;
    trainEnd = 1; tick(); trainEnd = 0; modelAcq = 0;
    // strobe while draining: must add nothing (R7)
    pixHit = '1; bxStrobe = 1; tick(); bxStrobe = 0; pixHit = '0;
    chk({tag, " R6 overflow"}, 32'(overOvf), 32'(modelOvf));
    forever begin
      bit stall;
      chk({tag, " R8 valid"}, 32'(rdValid), 32'd1);
      chk({tag, " R4 R5 word"}, 32'(rdData),
          (idx < expQ.size()) ? 32'(expQ[idx]) : 32'd0);
      stall = (stallEvery > 0) && ((n % stallEvery) == stallEvery - 1);
      n++;
      rdReady = !stall; tick(); rdReady = 0;
      if (!stall) begin
        if (idx == expQ.size()) break;
        idx++;
      end
    end
    chk({tag, " R8 valid low after end"}, 32'(rdValid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++; nRun++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] m;
    repeat (3) tick();
    chk("R1 rdValid", 32'(rdValid), 0);
    chk("R1 rdData", 32'(rdData), 0);
    chk("R1 overflow", 32'(overOvf), 0);
    rstN = 1; tick();
    chk("R1 idle after release", 32'(rdValid), 0);

    // strobe before any train is ignored (R7)
    crossing('1);
    chk("R7 idle strobe", 32'(rdValid), 0);

    // Train A: pixel 0 and all of group 3 masked (R2, R9)
    loadMask(42'h1 | (42'h3F << 18));
    startTrain();
    crossing('1);
    crossing(42'h1 | (42'h3F << 18));
    crossing(42'h2AAAAAAAAAA);
    crossing(42'h1 << 41);
    crossing('0);
    drain("trainA R2 R3 R9", 3);

    // Overflow train (R6)
    loadMask('0);
    startTrain();
    for (int k = 0; k < 4; k++) crossing('1);
    drain("overflow R6", 4);
    startTrain();
    chk("R6 cleared by trainStart", 32'(overOvf), 0);

    // Sweep of every group pattern under rotating masks (R2 R4 R9)
    for (int t = 0; t < 4; t++) begin
      m = '0;
      for (int g = 0; g < NG; g++) m[g*GS + t] = 1'b1;
      loadMask(m);
      startTrain();
      for (int k = 0; k < 16; k++) begin
        logic [NP-1:0] h;
        h = NP'(t*16 + k) << ((k % NG) * GS);
        crossing(h);
      end
      drain("sweep R4 R9", 5);
    end

    // Stamp saturation (R3)
    loadMask('0);
    startTrain();
    for (int k = 0; k < 8195; k++) begin
      if (k == 0 || k >= 8189) crossing(NP'(k % 63 + 1) << ((k % NG) * GS));
      else crossing('0);
    end
    chk("R3 last stamp saturated", 32'(expQ[expQ.size()-1][21:9]), TSMAX);
    drain("saturate R3", 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule